// File: doc/BRIEF.md
# Masked Error Interrupt Register Bank

This block gathers error events for a memory controller that has two pseudo channels, and turns them into one interrupt line per channel. Each channel watches eleven error conditions. Each condition arrives as a pulse one clock wide:

- single- and double-bit ECC errors from the DRAM
- parity errors on read data, on write data and on the address/command path
- a catastrophic over-temperature trip
- a calibration failure
- single- and double-bit errors in the write staging SRAM and in the read staging SRAM

For every condition the bank keeps a sticky valid flag and a saturating event counter. Software reaches all of this through an APB slave port. It can read the flags and the counts, and it clears them.

The interrupt of a channel rises when the channel's global enable is set and at least one condition that is not masked has an active record. A record is active while its valid flag is set or its counter is nonzero. The flag and the counter are cleared by separate writes. The interrupt therefore stays high until software has cleared both halves of every unmasked record. The interrupt is registered.

The register map has one page per channel. Channel 0 uses page 0x01 (addresses 0x01xx) and channel 1 uses page 0x02 (addresses 0x02xx).

Top module: `err_irq_bank`

## Requirements
- R1: After reset, the following hold on both channels. The control register reads 0x0FFE, which means enable off and all eleven masks set. The valid register, the status register and every counter read 0. Both irq outputs are low.
- R2: Register offsets within a channel page are 0x00 for control, 0x02 for status, 0x04 for valid, and 0x10 + 2*k for the counter of condition k (k = 0..10). Control bit 0 is the enable and control bit k+1 is the mask of condition k. Control bits 15:12 read 0 whatever is written.
- R3: Valid bit k sets in the clock after event k is pulsed. It stays set until a write to the valid register puts 1 in bit k. Writing 0 to a bit leaves it unchanged. An event in the same cycle as its clear keeps the bit set. Valid bits 15:11 read 0.
- R4: The counter of a condition increments once for each clock the event is high. It holds at 0xFFFF once it gets there.
- R5: Any write to a counter address clears that counter, whatever the write data. If the event arrives in the same cycle as the clear, the counter becomes 1.
- R6: Clearing a valid bit leaves its counter unchanged. Clearing a counter leaves its valid bit unchanged.
- R7: irq of a channel equals enable AND (OR over the unmasked conditions of (valid OR counter nonzero)). It is registered, so it follows a change of that state one clock later.
- R8: While a condition is unmasked and enabled, irq stays high after only its valid bit has been cleared. It drops one clock after its counter is also cleared.
- R9: A condition whose mask bit is 1 never raises irq. With the enable at 0, irq stays low whatever the records hold.
- R10: The status register returns the channel's irq in bit 0 and returns 0 in bits 15:1.
- R11: A read of any unmapped address returns 0. pready is always 1 and pslverr is always 0.
- R12: Events, clears and configuration on one channel have no effect on the other channel's registers or irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 16 | APB address |
| pwdata | input | 16 | APB write data |
| prdata | output | 16 | APB read data, combinational in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| err_evt | input | 22 | Error pulses; bit c*11+k is condition k of channel c |
| irq | output | 2 | Registered interrupt per channel |

## Verification
A wrong internal state always reaches a port. Consider a valid flag or counter that fails to set, or one that fails to clear. A read of that register in the same access shows it. The irq output of the channel shows it one clock after the faulty record changes, and only if that condition is unmasked and enabled. The bench therefore isolates one condition at a time with the mask. It then watches irq at each clear step, because a stale half of a record appears only as an interrupt that stays up after the second clear.

// File: rtl/err_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and register offsets of the error interrupt bank.
// Assumes 16-bit APB data and address; the channel page sits in paddr[15:8].
package err_irq_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 16;

    localparam logic [7:0] OFF_CTRL     = 8'h00;
    localparam logic [7:0] OFF_STAT     = 8'h02;
    localparam logic [7:0] OFF_VALID    = 8'h04;
    localparam logic [7:0] OFF_CNT_BASE = 8'h10;

    // Byte offset of the counter register of condition idx
    function automatic logic [7:0] cnt_offset(input int idx);
        return OFF_CNT_BASE + 8'(2 * idx);
    endfunction
endpackage

// File: rtl/err_cond_cell.sv
`timescale 1ns/1ps
// Module: one error condition record, made of a sticky valid flag and a saturating counter.
// Assumes evt is a synchronous pulse. An event wins over a clear in the same cycle.
module err_cond_cell #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr_valid,
    input  logic             clr_cnt,
    output logic             valid,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Sticky flag: set by event, cleared by write-one, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b0;
        else if (evt)
            valid <= 1'b1;
        else if (clr_valid)
            valid <= 1'b0;
    end

    // Saturating event counter with clear, event has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (evt) begin
            if (clr_cnt)
                cnt <= CNT_ONE;
            else if (cnt != CNT_MAX)
                cnt <= cnt + CNT_ONE;
        end else if (clr_cnt)
            cnt <= '0;
    end

    // Record contributes while either half is nonzero
    always_comb active = valid | (cnt != '0);
endmodule

// File: rtl/err_chan.sv
`timescale 1ns/1ps
// Module: register page and interrupt for one pseudo channel.
// Decodes its own page (addr[15:8] == PAGE) and returns zero read data outside it.
// Assumes wr_stb is a single-cycle APB write strobe and NCOND+1 <= REG_W.
module err_chan
    import err_irq_pkg::*;
#(
    parameter int         NCOND = 11,
    parameter int         CNT_W = 16,
    parameter logic [7:0] PAGE  = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wdata,
    input  logic [NCOND-1:0]       evt,
    output logic [REG_W-1:0]       rdata,
    output logic                   irq,
    output logic                   en,
    output logic [NCOND-1:0]       valid,
    output logic [NCOND*CNT_W-1:0] cnt_flat,
    output logic [NCOND-1:0]       clr_valid,
    output logic [NCOND-1:0]       clr_cnt
);
    localparam logic [NCOND:0] CTRL_RST = {{NCOND{1'b1}}, 1'b0};

    logic             page_hit;
    logic [7:0]       off;
    logic [NCOND:0]   ctrl_q;
    logic [NCOND-1:0] mask;
    logic [NCOND-1:0] active;
    logic [CNT_W-1:0] cnt_arr [NCOND];
    logic             irq_q;

    // Page and offset split of the incoming address
    always_comb begin
        page_hit = (addr[15:8] == PAGE);
        off      = addr[7:0];
    end

    // Control register: enable in bit 0, masks above it
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_stb && page_hit && off == OFF_CTRL)
            ctrl_q <= wdata[NCOND:0];
    end

    // Field split of the control register
    always_comb begin
        en   = ctrl_q[0];
        mask = ctrl_q[NCOND:1];
    end

    // Write-one-to-clear strobes for the valid flags
    always_comb begin
        if (wr_stb && page_hit && off == OFF_VALID)
            clr_valid = wdata[NCOND-1:0];
        else
            clr_valid = '0;
    end

    genvar k;
    generate
        for (k = 0; k < NCOND; k++) begin : g_cond
            // Counter clear strobe for condition k
            always_comb clr_cnt[k] = wr_stb && page_hit && (off == cnt_offset(k));

            err_cond_cell #(.CNT_W(CNT_W)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt       (evt[k]),
                .clr_valid (clr_valid[k]),
                .clr_cnt   (clr_cnt[k]),
                .valid     (valid[k]),
                .cnt       (cnt_arr[k]),
                .active    (active[k])
            );

            // Flattened counter view
            always_comb cnt_flat[k*CNT_W +: CNT_W] = cnt_arr[k];
        end
    endgenerate

    // Registered interrupt from enabled, unmasked, active records
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= en & (|(active & ~mask));
    end

    always_comb irq = irq_q;

    // Read mux of the page; unmapped offsets return zero
    always_comb begin
        rdata = '0;
        if (page_hit) begin
            if (off == OFF_CTRL)
                rdata = REG_W'(ctrl_q);
            else if (off == OFF_STAT)
                rdata = REG_W'(irq_q);
            else if (off == OFF_VALID)
                rdata = REG_W'(valid);
            else begin
                for (int i = 0; i < NCOND; i++)
                    if (off == cnt_offset(i))
                        rdata = REG_W'(cnt_arr[i]);
            end
        end
    end
endmodule

// File: rtl/err_irq_bank.sv
`timescale 1ns/1ps
// Module: top of the error interrupt bank, with an APB slave and NUM_CH channel pages.
// Channel c answers on page c+1. Accesses take no wait states and never return an error.
// Assumes err_evt is synchronous to pclk.
module err_irq_bank
    import err_irq_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int NUM_COND = 11,
    parameter int CNT_W    = 16
) (
    input  logic                         pclk,
    input  logic                         presetn,
    input  logic                         psel,
    input  logic                         penable,
    input  logic                         pwrite,
    input  logic [15:0]                  paddr,
    input  logic [15:0]                  pwdata,
    output logic [15:0]                  prdata,
    output logic                         pready,
    output logic                         pslverr,
    input  logic [NUM_CH*NUM_COND-1:0]   err_evt,
    output logic [NUM_CH-1:0]            irq
);
    localparam int NFLAT = NUM_CH * NUM_COND;

    logic                   wr_stb;
    logic [REG_W-1:0]       ch_rdata [NUM_CH];
    logic [NUM_CH-1:0]      chan_en;
    logic [NFLAT-1:0]       valid_all;
    logic [NFLAT-1:0]       clr_valid_all;
    logic [NFLAT-1:0]       clr_cnt_all;
    logic [NFLAT*CNT_W-1:0] cnt_all;

    // APB write strobe in the access phase
    always_comb wr_stb = psel & penable & pwrite;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            err_chan #(
                .NCOND (NUM_COND),
                .CNT_W (CNT_W),
                .PAGE  (8'(c + 1))
            ) u_chan (
                .clk       (pclk),
                .rst_n     (presetn),
                .wr_stb    (wr_stb),
                .addr      (paddr),
                .wdata     (pwdata),
                .evt       (err_evt[c*NUM_COND +: NUM_COND]),
                .rdata     (ch_rdata[c]),
                .irq       (irq[c]),
                .en        (chan_en[c]),
                .valid     (valid_all[c*NUM_COND +: NUM_COND]),
                .cnt_flat  (cnt_all[c*NUM_COND*CNT_W +: NUM_COND*CNT_W]),
                .clr_valid (clr_valid_all[c*NUM_COND +: NUM_COND]),
                .clr_cnt   (clr_cnt_all[c*NUM_COND +: NUM_COND])
            );
        end
    endgenerate

    // Merge the page read data; only reads drive non-zero data
    always_comb begin
        prdata = '0;
        if (psel && !pwrite)
            for (int i = 0; i < NUM_CH; i++)
                prdata = prdata | ch_rdata[i];
    end

    // Zero-wait, error-free responder
    always_comb begin
        pready  = 1'b1;
        pslverr = 1'b0;
    end
endmodule

// File: rtl/err_irq_bank_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the error interrupt bank, attached to the top by bind.
module err_irq_bank_chk #(
    parameter int NUM_CH   = 2,
    parameter int NUM_COND = 11,
    parameter int CNT_W    = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                psel,
    input logic                                pwrite,
    input logic [15:0]                         paddr,
    input logic [15:0]                         prdata,
    input logic                                pready,
    input logic                                pslverr,
    input logic [NUM_CH-1:0]                   irq,
    input logic [NUM_CH-1:0]                   en,
    input logic [NUM_CH*NUM_COND-1:0]          evt,
    input logic [NUM_CH*NUM_COND-1:0]          valid,
    input logic [NUM_CH*NUM_COND-1:0]          clr_valid,
    input logic [NUM_CH*NUM_COND-1:0]          clr_cnt,
    input logic [NUM_CH*NUM_COND*CNT_W-1:0]    cnt_all
);
    p_resp_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    p_stat_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr[7:0] == 8'h02) |-> (prdata[15:1] == 15'd0));

    genvar c, k;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_c
            p_irq_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !en[c] |=> !irq[c]);
        end
        for (k = 0; k < NUM_CH*NUM_COND; k++) begin : g_k
            p_valid_rise_needs_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(valid[k]) |-> $past(evt[k]));

            p_valid_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(valid[k]) |-> ($past(clr_valid[k]) && !$past(evt[k])));

            p_cnt_no_decrease_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_all[k*CNT_W +: CNT_W] >= $past(cnt_all[k*CNT_W +: CNT_W])) || $past(clr_cnt[k]));

            p_cnt_clear_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
                clr_cnt[k] |=> (cnt_all[k*CNT_W +: CNT_W] == CNT_W'($past(evt[k]))));
        end
    endgenerate
endmodule

bind err_irq_bank err_irq_bank_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_COND (NUM_COND),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (pclk),
    .rst_n     (presetn),
    .psel      (psel),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .irq       (irq),
    .en        (chan_en),
    .evt       (err_evt),
    .valid     (valid_all),
    .clr_valid (clr_valid_all),
    .clr_cnt   (clr_cnt_all),
    .cnt_all   (cnt_all)
);

// File: tb/tb_err_irq_bank.sv
`timescale 1ns/1ps
// Bench: sweeps every condition of both channels, checking at the APB port and the irq pins.
module tb_err_irq_bank;
    localparam int NCH = 2;
    localparam int NC  = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [15:0] paddr = '0, pwdata = '0;
    logic [15:0] prdata;
    logic        pready, pslverr;
    logic [NCH*NC-1:0] evt = '0;
    logic [NCH-1:0]    irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    err_irq_bank #(.NUM_CH(NCH), .NUM_COND(NC), .CNT_W(16)) dut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .err_evt(evt), .irq(irq)
    );

    function automatic logic [15:0] a_ctrl(input int c);  return 16'((c + 1) << 8);        endfunction
    function automatic logic [15:0] a_stat(input int c);  return 16'(((c + 1) << 8) + 2);  endfunction
    function automatic logic [15:0] a_valid(input int c); return 16'(((c + 1) << 8) + 4);  endfunction
    function automatic logic [15:0] a_cnt(input int c, input int k);
        return 16'(((c + 1) << 8) + 16 + 2 * k);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R11 pready/pslverr", {14'd0, pready, pslverr}, 16'h0002);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Hold event bit for n cycles, return at the negedge after the last sampling edge
    task automatic pulse(input int c, input int k, input int n);
        @(negedge clk);
        evt[c*NC + k] = 1'b1;
        repeat (n) @(negedge clk);
        evt[c*NC + k] = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
        logic [15:0] d;
        apb_rd(a, d);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", {14'd0, irq}, 16'h0000);
        for (int c = 0; c < NCH; c++) begin
            rd_chk("R1 ctrl reset", a_ctrl(c), 16'h0FFE);
            rd_chk("R1 valid reset", a_valid(c), 16'h0000);
            rd_chk("R1 status reset", a_stat(c), 16'h0000);
            for (int k = 0; k < NC; k++) rd_chk("R1 counter reset", a_cnt(c, k), 16'h0000);
        end

        // R2 reserved control bits
        apb_wr(a_ctrl(0), 16'hFFFF);
        rd_chk("R2 ctrl reserved bits", a_ctrl(0), 16'h0FFF);
        apb_wr(a_ctrl(0), 16'h0FFE);

        // Sweep every condition of every channel
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NC; k++) begin
                int n;
                logic [15:0] cw;
                n  = 1 + (k % 3);
                cw = 16'h0FFF & ~(16'h1 << (k + 1));
                apb_wr(a_ctrl(c), cw);
                rd_chk("R2 ctrl readback", a_ctrl(c), cw);
                pulse(c, k, n);
                @(negedge clk);
                check("R7 irq on unmasked event", {15'd0, irq[c]}, 16'h0001);
                check("R12 other channel irq quiet", {15'd0, irq[1-c]}, 16'h0000);
                rd_chk("R3 valid set", a_valid(c), 16'h1 << k);
                rd_chk("R12 other channel valid quiet", a_valid(1-c), 16'h0000);
                rd_chk("R4 counter value", a_cnt(c, k), 16'(n));
                rd_chk("R10 status bit", a_stat(c), 16'h0001);
                apb_wr(a_valid(c), 16'h0000);
                rd_chk("R3 write zero ignored", a_valid(c), 16'h1 << k);
                apb_wr(a_valid(c), 16'h1 << k);
                rd_chk("R3 valid cleared", a_valid(c), 16'h0000);
                rd_chk("R6 counter kept after valid clear", a_cnt(c, k), 16'(n));
                @(negedge clk);
                check("R8 irq held by counter", {15'd0, irq[c]}, 16'h0001);
                apb_wr(a_cnt(c, k), 16'hABCD);
                rd_chk("R5 counter cleared", a_cnt(c, k), 16'h0000);
                check("R8 irq dropped", {15'd0, irq[c]}, 16'h0000);
                rd_chk("R10 status cleared", a_stat(c), 16'h0000);

                // Masked condition, all others unmasked
                apb_wr(a_ctrl(c), 16'h0001 | (16'h1 << (k + 1)));
                pulse(c, k, 1);
                @(negedge clk);
                @(negedge clk);
                check("R9 masked condition ignored", {15'd0, irq[c]}, 16'h0000);
                apb_wr(a_cnt(c, k), 16'h0000);
                rd_chk("R6 valid kept after counter clear", a_valid(c), 16'h1 << k);
                apb_wr(a_valid(c), 16'h07FF);
                apb_wr(a_ctrl(c), 16'h0FFE);
            end
        end

        // R9 enable gate, then R7 registered response to enable
        apb_wr(a_ctrl(0), 16'h0000);
        pulse(0, 0, 1);
        @(negedge clk);
        @(negedge clk);
        check("R9 disabled irq low", {15'd0, irq[0]}, 16'h0000);
        apb_wr(a_ctrl(0), 16'h0001);
        @(negedge clk);
        check("R7 irq after enable", {15'd0, irq[0]}, 16'h0001);

        // R5 counter clear racing an event, R3 valid clear racing an event
        pulse(0, 0, 4);
        rd_chk("R4 counter accumulates", a_cnt(0, 0), 16'h0005);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a_cnt(0, 0); pwdata = 16'h0000;
        @(negedge clk);
        penable = 1'b1; evt[0] = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt[0] = 1'b0;
        rd_chk("R5 clear with event gives one", a_cnt(0, 0), 16'h0001);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a_valid(0); pwdata = 16'h0001;
        @(negedge clk);
        penable = 1'b1; evt[0] = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt[0] = 1'b0;
        rd_chk("R3 event beats valid clear", a_valid(0), 16'h0001);
        apb_wr(a_valid(0), 16'h0001);
        apb_wr(a_cnt(0, 0), 16'h0000);
        apb_wr(a_ctrl(0), 16'h0FFE);

        // R4 saturation on channel 1 condition 10
        pulse(1, 10, 65540);
        rd_chk("R4 counter saturates", a_cnt(1, 10), 16'hFFFF);
        rd_chk("R12 channel 0 untouched", a_valid(0), 16'h0000);
        apb_wr(a_cnt(1, 10), 16'h0000);
        rd_chk("R5 saturated counter cleared", a_cnt(1, 10), 16'h0000);

        // R11 unmapped reads
        rd_chk("R11 unmapped 0x0000", 16'h0000, 16'h0000);
        rd_chk("R11 unmapped 0x0106", 16'h0106, 16'h0000);
        rd_chk("R11 unmapped 0x0126", 16'h0126, 16'h0000);
        rd_chk("R11 unmapped 0x0300", 16'h0300, 16'h0000);
        rd_chk("R11 unmapped 0x0111", 16'h0111, 16'h0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule